// File: doc/BRIEF.md
# Receive Frame Early-Event Interrupt Generator

This block follows an incoming Ethernet frame one byte at a time and tells the host early that a frame is arriving, before the frame has finished. Each accepted byte is one handshake on a valid/ready stream, with start-of-frame and end-of-frame markers that travel with the byte. An external address filter gives a pass/fail verdict for the frame. The block samples that verdict on the beat that completes the 6-byte destination address. A frame that passes raises an address-passed event. Once 128 bytes of that frame have arrived, a 128-byte event is raised and the address-passed event is retired. A frame that fails the filter raises neither event.

The host reads a 16-bit event status word through a read strobe, and that read clears the pending flags. It writes a 16-bit enable word that selects which flags drive the level interrupt. Frames that were lost for lack of buffer space are reported on a pulse input. The block counts them in a 10-bit wrapping counter, and each wrap of that counter raises an overflow event.

The stream never back-pressures: ready is held high at all times, so every cycle with valid high is a consumed byte. Markers and verdict bits are ignored in cycles where valid is low. A byte with no start marker that arrives outside a frame is ignored.

Top module: `rx_early_irq`

## Requirements
- R1: After reset the status word, the enable word and the missed counter read zero, and irq is low.
- R2: When the 6th byte of a frame is accepted with da_pass high on that beat, status bit 15 (address-passed) reads 1 from the next cycle.
- R3: If da_pass is low on the 6th byte, the frame raises neither status bit 15 nor status bit 11.
- R4: When the 128th byte of a passing frame is accepted, status bit 11 (128-byte) reads 1 from the next cycle. Bit 15 reads 0 from that same cycle.
- R5: A frame shorter than 128 bytes never sets bit 11. A bit 15 left set from the previous frame reads 0 in the cycle after the next start-of-frame byte.
- R6: A stat_rd pulse returns the current status word and clears bits 15, 13, 11 and 10 at the next edge. An event that sets a flag in the same cycle as the read leaves that flag set.
- R7: cfg_wr stores cfg_wdata masked to the enable bits 15, 13, 11 and 10. The stored value reads back on cfg_rdata from the next cycle, with every other bit reading 0.
- R8: irq is high exactly when some status bit and the enable bit at the same position are both 1. It falls in the cycle after a read that clears the last such bit.
- R9: Each miss_evt pulse sets status bit 10 and increments miss_cnt. When miss_cnt steps from 1023 to 0, status bit 13 (overflow) is set.
- R10: rx_ready is always 1. Cycles with rx_valid low change nothing, even when rx_sof is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte beat present |
| rx_ready | output | 1 | Always high; the block never stalls |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| da_pass | input | 1 | Address filter verdict, sampled on the 6th byte |
| miss_evt | input | 1 | One frame lost for lack of buffer space |
| stat_rd | input | 1 | Host read of the status word (clears flags) |
| stat_rdata | output | 16 | Status word |
| cfg_wr | input | 1 | Host write of the enable word |
| cfg_wdata | input | 16 | Enable word write data |
| cfg_rdata | output | 16 | Enable word read back |
| miss_cnt | output | 10 | Missed-frame count |
| irq | output | 1 | Level interrupt |

## Verification
Each flag, the missed count and the enable word change at the first clock edge after the beat, pulse, read or write that causes them. irq and stat_rdata are decoded from registers alone, so they move together with the flags and not with the inputs. The bench drives inputs on falling edges and lets a reference model advance on the rising edge that samples them. It compares all outputs on the next falling edge, which is exactly one cycle after each stimulus. Directed cases take their expected words from the requirements and are checked at that same point. Examples are the 6th byte arriving together with a read, a sof pulse during a gap in valid, and the 1023-to-0 wrap of the counter.

// File: rtl/rx_early_pkg.sv
package rx_early_pkg;
  localparam int REG_W    = 16;
  localparam int NFLAG    = 4;
  // flag indices inside the block
  localparam int F_DEST   = 0;
  localparam int F_THR    = 1;
  localparam int F_MISS   = 2;
  localparam int F_OVF    = 3;
  // bit positions in the host-visible words (shared by status and enable)
  localparam int POS_DEST = 15;
  localparam int POS_THR  = 11;
  localparam int POS_MISS = 10;
  localparam int POS_OVF  = 13;

  function automatic int flag_pos(input int idx);
    case (idx)
      F_DEST:  return POS_DEST;
      F_THR:   return POS_THR;
      F_MISS:  return POS_MISS;
      default: return POS_OVF;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] enable_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NFLAG; i++) m[flag_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rx_frame_tracker.sv
module rx_frame_tracker #(
  parameter int DA_LEN = 6,
  parameter int THRESH = 128,
  localparam int CNT_W = $clog2(THRESH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic sof,
  input  logic eof,
  input  logic da_pass,
  output logic ev_sof,
  output logic ev_da,
  output logic ev_thr
);
  logic [CNT_W-1:0] cnt_q;
  logic             in_q;
  logic             pass_q;
  logic             cont;

  assign cont   = beat & ~sof & in_q;
  assign ev_sof = beat & sof;
  assign ev_da  = cont && (cnt_q == CNT_W'(DA_LEN - 1)) && da_pass;
  assign ev_thr = cont && (cnt_q == CNT_W'(THRESH - 1)) && pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      in_q   <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      if (ev_sof) begin
        cnt_q  <= CNT_W'(1);
        pass_q <= 1'b0;
      end else if (cont && cnt_q != CNT_W'(THRESH)) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      if (ev_da) pass_q <= 1'b1;
      if (beat && (sof || in_q)) in_q <= ~eof;
    end
  end

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> (cnt_q == CNT_W'(1) && !pass_q)); // R5
endmodule

// File: rtl/rx_miss_counter.sv
module rx_miss_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         miss,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = miss && (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (miss) cnt <= cnt + W'(1);
  end

  AST_MISS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && cnt == {W{1'b1}}) |=> (cnt == '0)); // R9
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && cnt != {W{1'b1}}) |=> (cnt == $past(cnt) + W'(1))); // R9
endmodule

// File: rtl/rx_event_flags.sv
module rx_event_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (set_v[i]) q[i] <= 1'b1;
      else if (clr_v[i]) q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_v[i] |=> q[i]); // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_v[i] && !set_v[i]) |=> !q[i]); // R6
  end
endmodule

// File: rtl/rx_early_irq.sv
module rx_early_irq
  import rx_early_pkg::*;
#(
  parameter int DA_LEN = 6,
  parameter int THRESH = 128,
  parameter int MISS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              da_pass,
  input  logic              miss_evt,
  input  logic              stat_rd,
  output logic [REG_W-1:0]  stat_rdata,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic [MISS_W-1:0] miss_cnt,
  output logic              irq
);
  localparam logic [REG_W-1:0] CFG_MASK = enable_mask();

  logic             beat;
  logic             ev_sof, ev_da, ev_thr, ev_ovf;
  logic [NFLAG-1:0] set_v, clr_v, flags;
  logic [REG_W-1:0] cfg_q;

  assign rx_ready = 1'b1;
  assign beat     = rx_valid & rx_ready;

  rx_frame_tracker #(.DA_LEN(DA_LEN), .THRESH(THRESH)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(rx_sof), .eof(rx_eof),
    .da_pass(da_pass), .ev_sof(ev_sof), .ev_da(ev_da), .ev_thr(ev_thr)
  );

  rx_miss_counter #(.W(MISS_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .miss(miss_evt), .cnt(miss_cnt), .wrap(ev_ovf)
  );

  always_comb begin
    set_v         = '0;
    set_v[F_DEST] = ev_da;
    set_v[F_THR]  = ev_thr;
    set_v[F_MISS] = miss_evt;
    set_v[F_OVF]  = ev_ovf;
    clr_v         = {NFLAG{stat_rd}};
    clr_v[F_DEST] = stat_rd | ev_thr | ev_sof;
  end

  rx_event_flags #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .q(flags)
  );

  always_comb begin
    stat_rdata = '0;
    for (int i = 0; i < NFLAG; i++) stat_rdata[flag_pos(i)] = flags[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_wdata & CFG_MASK;
  end

  assign cfg_rdata = cfg_q;
  assign irq       = |(stat_rdata & cfg_q);

  AST_THR_RETIRES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    ev_thr |=> (stat_rdata[POS_THR] && !stat_rdata[POS_DEST])); // R4
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_v == '0) |=> !irq); // R8
  AST_CFG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ((cfg_rdata & ~CFG_MASK) == '0)); // R7
endmodule

// File: tb/rx_early_irq_test.sv
`timescale 1ns/1ps
module rx_early_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, da_pass, miss_evt, stat_rd, cfg_wr;
  logic        rx_ready, irq;
  logic [15:0] cfg_wdata, stat_rdata, cfg_rdata;
  logic [9:0]  miss_cnt;

  int errors = 0;
  int checks = 0;
  bit mon_on = 0;
  bit done   = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  rx_early_irq uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .da_pass(da_pass), .miss_evt(miss_evt),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .miss_cnt(miss_cnt), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // reference model, built from the requirements
  int m_len; bit m_in, m_pass;
  bit e_dest, e_thr, e_miss, e_ovf;
  int e_cnt;
  logic [15:0] e_cfg;

  function automatic logic [15:0] exp_stat();
    logic [15:0] s;
    s = '0;
    s[15] = e_dest; s[11] = e_thr; s[10] = e_miss; s[13] = e_ovf;
    return s;
  endfunction

  always @(posedge clk) begin
    bit sd, s128;
    cyc++;
    if (!rst_n) begin
      m_len = 0; m_in = 0; m_pass = 0;
      e_dest = 0; e_thr = 0; e_miss = 0; e_ovf = 0; e_cnt = 0; e_cfg = '0;
    end else begin
      sd = 0; s128 = 0;
      if (rx_valid) begin
        if (rx_sof) begin m_len = 1; m_in = 1; m_pass = 0; end
        else if (m_in) begin
          if (m_len < 1000) m_len++;
          if (m_len == 6 && da_pass) begin m_pass = 1; sd = 1; end
          if (m_len == 128 && m_pass) s128 = 1;
        end
        if (rx_eof) m_in = 0;
      end
      if (stat_rd) begin e_dest = 0; e_thr = 0; e_miss = 0; e_ovf = 0; end
      if (rx_valid && rx_sof) e_dest = 0;
      if (s128) begin e_dest = 0; e_thr = 1; end
      if (sd) e_dest = 1;
      if (miss_evt) begin
        e_miss = 1;
        if (e_cnt == 1023) begin e_cnt = 0; e_ovf = 1; end else e_cnt++;
      end
      if (cfg_wr) e_cfg = cfg_wdata & 16'hAC00;
    end
  end

  // cycle-by-cycle comparison; outputs depend only on registers
  always @(negedge clk) begin
    if (mon_on && !done) begin
      chk(stat_rdata == exp_stat(), "R6 status word", 32'(stat_rdata), 32'(exp_stat()));
      chk(irq == |(exp_stat() & e_cfg), "R8 irq level", 32'(irq), 32'(|(exp_stat() & e_cfg)));
      chk(miss_cnt == 10'(e_cnt), "R9 miss count", 32'(miss_cnt), 32'(e_cnt));
      chk(cfg_rdata == e_cfg, "R7 enable readback", 32'(cfg_rdata), 32'(e_cfg));
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic quiet();
    rx_valid = 0; rx_sof = 0; rx_eof = 0; da_pass = 0;
    miss_evt = 0; stat_rd = 0; cfg_wr = 0; cfg_wdata = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); quiet(); end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk); quiet(); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); quiet();
  endtask

  task automatic host_read();
    @(negedge clk); quiet(); stat_rd = 1;
    @(negedge clk); quiet();
  endtask

  task automatic send_frame(input int len, input bit pass, input int rd_idx, input bit noisy);
    for (int i = 0; i < len; i++) begin
      if (noisy && ($urandom % 4 == 0)) begin
        @(negedge clk); quiet();
        rx_sof = 1'($urandom); da_pass = 1'($urandom); stat_rd = ($urandom % 8 == 0);
      end
      @(negedge clk); quiet();
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      da_pass  = (i == 5) ? pass : 1'($urandom);
      stat_rd  = (i == rd_idx) || (noisy && ($urandom % 16 == 0));
      miss_evt = noisy && ($urandom % 32 == 0);
      if (noisy && ($urandom % 64 == 0)) begin cfg_wr = 1; cfg_wdata = 16'($urandom); end
    end
    @(negedge clk); quiet();
  endtask

  initial begin
    void'($urandom(32'h5EED_0B17));
    quiet();
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(stat_rdata == 16'h0 && cfg_rdata == 16'h0 && miss_cnt == 0, "R1 reset state",
        {stat_rdata, cfg_rdata}, 32'h0);
    chk(irq == 0, "R1 irq at reset", 32'(irq), 0);
    chk(rx_ready == 1, "R10 ready high", 32'(rx_ready), 1);
    mon_on = 1;

    cfg_write(16'hFFFF);
    chk(cfg_rdata == 16'hAC00, "R7 masked enable", 32'(cfg_rdata), 32'hAC00);
    cfg_write(16'h8000);

    send_frame(10, 1, -1, 0);
    chk(stat_rdata == 16'h8000, "R2 address-passed", 32'(stat_rdata), 32'h8000);
    chk(irq == 1, "R8 irq raised", 32'(irq), 1);
    host_read();
    chk(stat_rdata == 16'h0, "R6 read clears", 32'(stat_rdata), 0);
    chk(irq == 0, "R8 irq drops after read", 32'(irq), 0);

    send_frame(200, 1, -1, 0);
    chk(stat_rdata == 16'h0800, "R4 128-byte retires dest", 32'(stat_rdata), 32'h0800);
    chk(irq == 0, "R8 disabled flag masked", 32'(irq), 0);
    host_read();

    send_frame(200, 0, -1, 0);
    chk(stat_rdata == 16'h0, "R3 failed frame silent", 32'(stat_rdata), 0);

    send_frame(100, 1, -1, 0);
    chk(stat_rdata == 16'h8000, "R5 short frame no 128", 32'(stat_rdata), 32'h8000);
    @(negedge clk); quiet(); rx_valid = 1; rx_sof = 1; da_pass = 1;
    @(negedge clk); quiet();
    chk(stat_rdata == 16'h0, "R5 sof clears dest", 32'(stat_rdata), 0);
    rx_valid = 1; rx_eof = 1;
    @(negedge clk); quiet();

    send_frame(10, 1, 5, 0);
    chk(stat_rdata == 16'h8000, "R6 set wins over read", 32'(stat_rdata), 32'h8000);
    send_frame(130, 1, 127, 0);
    chk(stat_rdata == 16'h0800, "R6 128 set wins over read", 32'(stat_rdata), 32'h0800);
    host_read();

    // gaps: valid low with sof high must be ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); quiet(); rx_valid = 1; rx_sof = (i == 0); da_pass = 1;
      @(negedge clk); quiet(); rx_sof = 1; da_pass = 1;
    end
    @(negedge clk); quiet();
    chk(stat_rdata == 16'h8000, "R10 idle cycles ignored", 32'(stat_rdata), 32'h8000);
    @(negedge clk); quiet(); rx_valid = 1; rx_eof = 1;
    host_read();

    cfg_write(16'h2000);
    for (int i = 0; i < 1023; i++) begin @(negedge clk); quiet(); miss_evt = 1; end
    @(negedge clk); quiet();
    chk(miss_cnt == 10'd1023 && stat_rdata == 16'h0400, "R9 before wrap",
        {6'd0, miss_cnt, stat_rdata}, {16'd1023, 16'h0400});
    chk(irq == 0, "R8 miss not enabled", 32'(irq), 0);
    miss_evt = 1;
    @(negedge clk); quiet();
    chk(miss_cnt == 10'd0 && stat_rdata == 16'h2400, "R9 wrap sets overflow",
        {6'd0, miss_cnt, stat_rdata}, {16'd0, 16'h2400});
    chk(irq == 1, "R8 overflow irq", 32'(irq), 1);
    host_read();

    cfg_write(16'hAC00);
    for (int f = 0; f < 300; f++) begin
      send_frame(1 + int'($urandom % 260), 1'($urandom % 4 != 0), -1, 1);
      idle(int'($urandom % 3));
    end
    idle(4);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule